// File: doc/BRIEF.md
# Sign-Aware Significand Rounder

This block narrows a sign-magnitude significand. The input significand carries a field of extra low-order guard bits below its least significant kept bit. The block drops those guard bits and adjusts the kept magnitude according to one of four rounding directions, chosen by a 2-bit code that travels with each operand. The kept magnitude is either left as it is or incremented by one at its least significant bit. Some directions depend on the sign. The nearest direction uses the exact-halfway guard pattern to break ties toward an even result.

Each operand arrives with `in_valid` and is registered. The rounded magnitude, a carry flag and an inexact flag appear one clock later with `out_valid`. The carry flag marks an increment that overflowed the kept width. The caller is responsible for any exponent correction that follows. A two-state controller tracks whether the output register holds a fresh result. State `ST_IDLE` goes to `ST_RESULT` when `in_valid` is high. `ST_RESULT` stays in `ST_RESULT` while `in_valid` remains high and returns to `ST_IDLE` otherwise. Synchronous reset forces `ST_IDLE`.

Top module: `mant_round_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high and low otherwise. Synchronous reset clears it and clears the result outputs.
- R2: With mode code 00 (nearest, the all-zero default code), a guard field above half (top guard bit 1 and some lower guard bit 1) increments the magnitude. A guard field below half (top guard bit 0) leaves the magnitude unchanged.
- R3: With mode code 00, a guard field of exactly one followed by zeros increments the magnitude only when the kept LSB is 1, so the result is even.
- R4: With mode code 01 (toward zero), the output equals the kept bits unchanged, and carry is 0, for either sign.
- R5: With mode code 10 (toward plus infinity), a positive operand with any nonzero guard bit increments. A negative operand is never incremented.
- R6: With mode code 11 (toward minus infinity), a negative operand with any nonzero guard bit increments. A positive operand is never incremented.
- R7: `out_inexact` is 1 exactly when the guard field of the operand was nonzero, in every mode.
- R8: An increment of an all-ones kept magnitude sets `out_carry` and wraps `out_sig` to zero. Otherwise `out_carry` is 0.
- R9: An operand with an all-zero guard field passes through unchanged, with no carry, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_sign | input | 1 | Operand sign, 1 for negative |
| in_sig | input | KEEP_W+GUARD_W | Kept magnitude in the upper bits, guard field in the low GUARD_W bits |
| in_mode | input | 2 | Rounding direction code: 00 nearest, 01 zero, 10 plus, 11 minus |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_sig | output | KEEP_W | Rounded magnitude |
| out_carry | output | 1 | Increment overflowed the kept width |
| out_inexact | output | 1 | Some guard bit was nonzero |

## Verification
The cycle-by-cycle properties cover the following behaviours:
- The one-cycle valid relation.
- The inexact flag against the registered guard field.
- Pass-through in toward-zero mode and for exact operands.
- The sign-gated no-increment halves of the two directed modes.
- The wrap-to-zero on carry.

The bench's directed scenarios are the only place where the increment decisions themselves are compared with hand-computed values. These include the tie cases 2.5 to 2 and 3.5 to 4, the above-half and below-half splits, the signed directed increments, and the all-ones overflow.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_PLUS    = 2'b10,
        RM_MINUS   = 2'b11
    } round_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
    import mant_round_pkg::*;
#(
    parameter int GUARD_W = 3
) (
    input  logic               sign,
    input  logic               kept_lsb,
    input  logic [GUARD_W-1:0] guard,
    input  round_mode_e        mode,
    output logic               bump,
    output logic               lost
);
    localparam logic [GUARD_W-1:0] HALF = GUARD_W'(1) << (GUARD_W - 1);

    logic over_half;
    logic at_half;

    always_comb begin
        lost      = |guard;
        over_half = guard > HALF;
        at_half   = guard == HALF;
        unique case (mode)
            RM_NEAREST: bump = over_half | (at_half & kept_lsb);
            RM_ZERO:    bump = 1'b0;
            RM_PLUS:    bump = lost & ~sign;
            RM_MINUS:   bump = lost & sign;
            default:    bump = 1'b0;
        endcase
    end
endmodule

// File: rtl/mant_round_incr.sv
module mant_round_incr #(
    parameter int KEEP_W = 8
) (
    input  logic [KEEP_W-1:0] kept,
    input  logic              bump,
    output logic [KEEP_W-1:0] sum,
    output logic              ovf
);
    always_comb begin
        {ovf, sum} = {1'b0, kept} + {{KEEP_W{1'b0}}, bump};
    end
endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
    import mant_round_pkg::*;
#(
    parameter int KEEP_W  = 8,
    parameter int GUARD_W = 3,
    localparam int SIG_W  = KEEP_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [SIG_W-1:0]  in_sig,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [KEEP_W-1:0] out_sig,
    output logic              out_carry,
    output logic              out_inexact
);
    ctl_state_e        state_q, state_d;
    round_mode_e       mode;
    logic [KEEP_W-1:0] kept;
    logic [GUARD_W-1:0] guard;
    logic              bump, lost, ovf;
    logic [KEEP_W-1:0] sum;

    assign mode  = round_mode_e'(in_mode);
    assign kept  = in_sig[SIG_W-1:GUARD_W];
    assign guard = in_sig[GUARD_W-1:0];

    mant_round_decide #(.GUARD_W(GUARD_W)) u_decide (
        .sign     (in_sign),
        .kept_lsb (kept[0]),
        .guard    (guard),
        .mode     (mode),
        .bump     (bump),
        .lost     (lost)
    );

    mant_round_incr #(.KEEP_W(KEEP_W)) u_incr (
        .kept (kept),
        .bump (bump),
        .sum  (sum),
        .ovf  (ovf)
    );

    // next-state decision
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // result register, loaded whenever an operand arrives
    always_ff @(posedge clk) begin
        if (rst) begin
            out_sig     <= '0;
            out_carry   <= 1'b0;
            out_inexact <= 1'b0;
        end else if (in_valid) begin
            out_sig     <= sum;
            out_carry   <= ovf;
            out_inexact <= lost;
        end
    end

    // outputs decoded from state
    always_comb begin
        out_valid = (state_q == ST_RESULT);
    end
endmodule

// File: rtl/mant_round_chk.sv
module mant_round_chk #(
    parameter int KEEP_W  = 8,
    parameter int GUARD_W = 3,
    localparam int SIG_W  = KEEP_W + GUARD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sign,
    input logic [SIG_W-1:0]  in_sig,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic [KEEP_W-1:0] out_sig,
    input logic              out_carry,
    input logic              out_inexact
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_INEXACT_FLAG: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_inexact == ($past(in_sig[GUARD_W-1:0]) != '0)); // R7
    AST_ZERO_MODE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01) |=> (out_sig == $past(in_sig[SIG_W-1:GUARD_W]) && !out_carry)); // R4
    AST_PLUS_NEG_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b10 && in_sign) |=> (out_sig == $past(in_sig[SIG_W-1:GUARD_W]))); // R5
    AST_MINUS_POS_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b11 && !in_sign) |=> (out_sig == $past(in_sig[SIG_W-1:GUARD_W]))); // R6
    AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_carry) |-> out_sig == '0); // R8
    AST_EXACT_PASSES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sig[GUARD_W-1:0] == '0) |=> (out_sig == $past(in_sig[SIG_W-1:GUARD_W]) && !out_carry)); // R9
endmodule

bind mant_round_unit mant_round_chk #(.KEEP_W(KEEP_W), .GUARD_W(GUARD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sign     (in_sign),
    .in_sig      (in_sig),
    .in_mode     (in_mode),
    .out_valid   (out_valid),
    .out_sig     (out_sig),
    .out_carry   (out_carry),
    .out_inexact (out_inexact)
);

// File: tb/mant_round_unit_tb.sv
`timescale 1ns/1ps
module mant_round_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_sign;
    logic [10:0] in_sig;
    logic [1:0]  in_mode;
    logic        out_valid;
    logic [7:0]  out_sig;
    logic        out_carry;
    logic        out_inexact;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    mant_round_unit #(.KEEP_W(8), .GUARD_W(3)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
        .in_sig(in_sig), .in_mode(in_mode), .out_valid(out_valid),
        .out_sig(out_sig), .out_carry(out_carry), .out_inexact(out_inexact)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one operand in, result checked one clock later
    task automatic round_one(input logic sgn, input logic [7:0] kept, input logic [2:0] g,
                             input logic [1:0] mode, input logic [7:0] e_sig,
                             input logic e_carry, input logic e_inex, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_sign = sgn; in_sig = {kept, g}; in_mode = mode;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, 16'(out_valid), 16'd1);
        chk({tag, " sig"}, 16'(out_sig), 16'(e_sig));
        chk({tag, " carry"}, 16'(out_carry), 16'(e_carry));
        chk({tag, " inexact"}, 16'(out_inexact), 16'(e_inex));
    endtask

    task automatic test_reset();
        chk("R1 reset valid", 16'(out_valid), 16'd0);
        chk("R1 reset sig", 16'(out_sig), 16'd0);
    endtask

    task automatic test_nearest();
        round_one(1'b0, 8'd2, 3'b101, 2'b00, 8'd3, 1'b0, 1'b1, "R2 above half");
        round_one(1'b1, 8'd2, 3'b011, 2'b00, 8'd2, 1'b0, 1'b1, "R2 below half");
        round_one(1'b0, 8'd2, 3'b100, 2'b00, 8'd2, 1'b0, 1'b1, "R3 tie even stays");
        round_one(1'b1, 8'd3, 3'b100, 2'b00, 8'd4, 1'b0, 1'b1, "R3 tie odd bumps");
    endtask

    task automatic test_directed();
        round_one(1'b0, 8'd5, 3'b111, 2'b01, 8'd5, 1'b0, 1'b1, "R4 zero pos");
        round_one(1'b1, 8'd5, 3'b111, 2'b01, 8'd5, 1'b0, 1'b1, "R4 zero neg");
        round_one(1'b0, 8'd2, 3'b001, 2'b10, 8'd3, 1'b0, 1'b1, "R5 plus pos");
        round_one(1'b1, 8'd2, 3'b111, 2'b10, 8'd2, 1'b0, 1'b1, "R5 plus neg");
        round_one(1'b0, 8'd1, 3'b111, 2'b11, 8'd1, 1'b0, 1'b1, "R6 minus pos");
        round_one(1'b1, 8'd1, 3'b111, 2'b11, 8'd2, 1'b0, 1'b1, "R6 minus neg");
    endtask

    task automatic test_exact();
        for (int m = 0; m < 4; m++)
            round_one(m[0], 8'd7, 3'b000, 2'(m), 8'd7, 1'b0, 1'b0, "R9 R7 exact");
    endtask

    task automatic test_carry();
        round_one(1'b0, 8'hFF, 3'b100, 2'b00, 8'h00, 1'b1, 1'b1, "R8 tie wrap");
        round_one(1'b0, 8'hFF, 3'b001, 2'b10, 8'h00, 1'b1, 1'b1, "R8 plus wrap");
        round_one(1'b0, 8'hFF, 3'b011, 2'b00, 8'hFF, 1'b0, 1'b1, "R8 no wrap");
    endtask

    task automatic test_idle();
        round_one(1'b0, 8'd9, 3'b000, 2'b00, 8'd9, 1'b0, 1'b0, "R1 single");
        @(negedge clk);
        chk("R1 idle valid", 16'(out_valid), 16'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sign = 1'b0; in_sig = '0; in_mode = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_nearest();
        test_directed();
        test_exact();
        test_carry();
        test_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule